// File: doc/BRIEF.md
# STS-1 Payload Pointer Interpreter

This block follows the position of the synchronous payload envelope inside an STS-1 frame. Once per frame the line-side framer presents the two pointer bytes and a one-cycle strobe. The block splits the pair into a 4-bit flag nibble and a 10-bit offset word. It compares the word against the offset it currently holds and sorts the frame into one of five classes: normal, increment, decrement, new pointer or bad. It then updates the held offset and pulses an indication for one cycle.

Downstream payload logic uses the indications directly. An increment pulse means the byte that follows H3 in this frame is a stuff byte and must be dropped. A decrement pulse means H3 itself carries payload. The offset output counts bytes from row 4, column 4. The value shown after a strobe applies to the frames that follow.

The tracker has two named states. In `ST_STEADY` every class is acted on. In `ST_GUARD`, which lasts exactly one frame after any adjustment, increment and decrement commands are ignored. Its transitions are:
- `T_ADJUST`: ST_STEADY to ST_GUARD, on an accepted increment, decrement or new pointer.
- `T_RELOAD`: ST_GUARD to ST_GUARD, on a new pointer.
- `T_SETTLE`: ST_GUARD to ST_STEADY, on any other frame.
- `T_HOLD`: ST_STEADY to ST_STEADY, on a normal or bad frame.

Top module: `ptr_interp`

## Requirements
- R1: The offset word is {h1_byte[1:0], h2_byte} and the flag nibble is h1_byte[7:4]. Bits 9, 7, 5, 3 and 1 of the word are the I bits; bits 8, 6, 4, 2 and 0 are the D bits.
- R2: Reset (rst_n low) sets the offset to 0, clears all four indications and enters ST_STEADY, so the first command after reset is acted on.
- R3: In ST_STEADY, a frame whose flag nibble is not 1001, with at least three of five I bits differing from the held offset and fewer than three D bits differing, pulses stuff_after_h3 and adds one to the offset.
- R4: In ST_STEADY, a frame whose flag nibble is not 1001, with at least three of five D bits differing and fewer than three I bits differing, pulses data_in_h3 and subtracts one from the offset.
- R5: An increment from 782 gives 0 and a decrement from 0 gives 782. The offset never exceeds 782.
- R6: A flag nibble of 1001 with a word of 782 or less loads the word as the offset and pulses new_ptr, in either state.
- R7: A flag nibble of 1001 with a word above 782 pulses ptr_invalid and leaves the offset unchanged. So does a frame that is not a justification and whose word is above 782.
- R8: A frame whose word is 782 or less and that matches none of R3, R4 or R6 changes nothing and raises no indication, even when the word differs from the held offset.
- R9: In the single frame after an accepted adjustment (ST_GUARD), increment and decrement commands raise no indication and leave the offset unchanged. The frame after that is handled normally again.
- R10: Indications are one-cycle pulses in the cycle after the strobe, and at most one is high at a time. Without a strobe, the offset and indications do not change.
- R11: A word with at least three I bits and at least three D bits differing is not a justification. It is judged by its value, as in R7 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | High for one cycle when the pointer bytes are valid |
| h1_byte | input | 8 | First pointer byte: flag nibble and the top two offset bits |
| h2_byte | input | 8 | Second pointer byte: the low eight offset bits |
| offset | output | 10 | Held payload offset, 0 to 782 |
| stuff_after_h3 | output | 1 | Increment pulse: the byte after H3 is stuff |
| data_in_h3 | output | 1 | Decrement pulse: H3 carries payload |
| new_ptr | output | 1 | A new offset was loaded |
| ptr_invalid | output | 1 | The received pointer was out of range |

## Verification
Two functions can meet in one cycle. The guard window, which suppresses justification, can coincide with a frame that carries an increment command, a decrement command or a new-pointer load. The bench provokes this by sending a justification word and a new-pointer word in the frame right after an adjustment. In the first case it expects no indication and an unchanged offset. In the second it expects the load to take effect anyway. The wrap boundaries are also driven through justification. Both wrap directions are judged by the exact offset and by the pulse seen one cycle after the strobe.

// File: rtl/ptr_pkg.sv
`timescale 1ns/1ps
package ptr_pkg;
    localparam int BYTE_W = 8;
    localparam int FLAG_W = 4;

    typedef enum logic [2:0] {
        CL_NORMAL,
        CL_INC,
        CL_DEC,
        CL_NEWPTR,
        CL_BAD
    } ptr_class_e;

    typedef enum logic {
        ST_STEADY,
        ST_GUARD
    } trk_state_e;
endpackage

// File: rtl/ptr_word_decode.sv
`timescale 1ns/1ps
module ptr_word_decode
    import ptr_pkg::*;
#(
    parameter int         PTR_W   = 10,
    parameter int         MAX_OFS = 782,
    parameter int         MAJ     = 3,
    parameter logic [3:0] FLAG_SET = 4'b1001
) (
    input  logic [BYTE_W-1:0] h1_byte,
    input  logic [BYTE_W-1:0] h2_byte,
    input  logic [PTR_W-1:0]  held_ofs,
    output logic [PTR_W-1:0]  rx_value,
    output ptr_class_e        cls
);
    localparam int PAIRS = PTR_W / 2;
    localparam int CNT_W = $clog2(PAIRS + 1);

    logic [2*BYTE_W-1:0] word_all;
    logic [FLAG_W-1:0]   flag_nib;
    logic [PTR_W-1:0]    diff;
    logic [PAIRS-1:0]    i_diff;
    logic [PAIRS-1:0]    d_diff;
    logic [CNT_W-1:0]    i_cnt;
    logic [CNT_W-1:0]    d_cnt;
    logic                i_maj;
    logic                d_maj;
    logic                over_range;
    logic                size_bits_unused;

    // R1: offset word in the low bits, flag nibble in the top of the first byte
    assign word_all         = {h1_byte, h2_byte};
    assign rx_value         = word_all[PTR_W-1:0];
    assign flag_nib         = h1_byte[BYTE_W-1 -: FLAG_W];
    assign size_bits_unused = ^word_all[2*BYTE_W-FLAG_W-1:PTR_W];
    assign diff             = rx_value ^ held_ofs;

    // R1: odd positions carry the I bits, even positions the D bits
    generate
        for (genvar g = 0; g < PAIRS; g++) begin : g_pair
            assign i_diff[g] = diff[2*g+1];
            assign d_diff[g] = diff[2*g];
        end
    endgenerate

    always_comb begin
        i_cnt = '0;
        d_cnt = '0;
        for (int k = 0; k < PAIRS; k++) begin
            i_cnt = i_cnt + CNT_W'(i_diff[k]);
            d_cnt = d_cnt + CNT_W'(d_diff[k]);
        end
    end

    assign i_maj      = (int'(i_cnt) >= MAJ);
    assign d_maj      = (int'(d_cnt) >= MAJ);
    assign over_range = (int'(rx_value) > MAX_OFS);

    // R6/R7 flag nibble first, then R3/R4/R11 majority vote, then R7/R8 range
    always_comb begin
        if (flag_nib == FLAG_SET) begin
            cls = over_range ? CL_BAD : CL_NEWPTR;
        end else if (i_maj && !d_maj) begin
            cls = CL_INC;
        end else if (d_maj && !i_maj) begin
            cls = CL_DEC;
        end else begin
            cls = over_range ? CL_BAD : CL_NORMAL;
        end
    end

    always_comb begin
        assert ((cls != CL_INC && cls != CL_DEC) || (flag_nib != FLAG_SET))
            else $error("p_flag_priority_r6");
    end
endmodule

// File: rtl/ptr_track_fsm.sv
`timescale 1ns/1ps
module ptr_track_fsm
    import ptr_pkg::*;
#(
    parameter int PTR_W   = 10,
    parameter int MAX_OFS = 782
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  ptr_class_e       cls,
    input  logic [PTR_W-1:0] rx_value,
    output logic [PTR_W-1:0] offset,
    output logic             inc_flag,
    output logic             dec_flag,
    output logic             newptr_flag,
    output logic             invalid_flag
);
    localparam logic [PTR_W-1:0] MAX_V = PTR_W'(MAX_OFS);

    trk_state_e       state, nxt_state;
    logic [PTR_W-1:0] ofs_q, nxt_ofs;
    logic             nxt_inc, nxt_dec, nxt_new, nxt_bad;
    logic [PTR_W-1:0] ofs_up, ofs_dn;

    // R5: wrap at both ends of the offset range
    assign ofs_up = (ofs_q == MAX_V) ? '0 : ofs_q + 1'b1;
    assign ofs_dn = (ofs_q == '0) ? MAX_V : ofs_q - 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STEADY;
        else        state <= nxt_state;
    end

    // transitions
    always_comb begin
        nxt_state = state;
        if (frame_strobe) begin
            unique case (state)
                ST_STEADY: begin
                    if (cls == CL_INC || cls == CL_DEC || cls == CL_NEWPTR)
                        nxt_state = ST_GUARD;        // T_ADJUST
                end
                ST_GUARD: begin
                    if (cls == CL_NEWPTR) nxt_state = ST_GUARD;   // T_RELOAD
                    else                  nxt_state = ST_STEADY;  // T_SETTLE
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        nxt_ofs = ofs_q;
        nxt_inc = 1'b0;
        nxt_dec = 1'b0;
        nxt_new = 1'b0;
        nxt_bad = 1'b0;
        if (frame_strobe) begin
            unique case (state)
                ST_STEADY: begin
                    case (cls)
                        CL_INC:    begin nxt_inc = 1'b1; nxt_ofs = ofs_up; end
                        CL_DEC:    begin nxt_dec = 1'b1; nxt_ofs = ofs_dn; end
                        CL_NEWPTR: begin nxt_new = 1'b1; nxt_ofs = rx_value; end
                        CL_BAD:    nxt_bad = 1'b1;
                        default:   nxt_ofs = ofs_q;
                    endcase
                end
                ST_GUARD: begin
                    // R9: justification commands are dropped here
                    case (cls)
                        CL_NEWPTR: begin nxt_new = 1'b1; nxt_ofs = rx_value; end
                        CL_BAD:    nxt_bad = 1'b1;
                        default:   nxt_ofs = ofs_q;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q        <= '0;
            inc_flag     <= 1'b0;
            dec_flag     <= 1'b0;
            newptr_flag  <= 1'b0;
            invalid_flag <= 1'b0;
        end else begin
            ofs_q        <= nxt_ofs;
            inc_flag     <= nxt_inc;
            dec_flag     <= nxt_dec;
            newptr_flag  <= nxt_new;
            invalid_flag <= nxt_bad;
        end
    end

    assign offset = ofs_q;

    p_ofs_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        offset <= MAX_V);

    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc_flag, dec_flag, newptr_flag, invalid_flag}));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> (!inc_flag && !dec_flag && !newptr_flag && !invalid_flag
                           && $stable(offset)));

    p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && state == ST_GUARD) |=> (!inc_flag && !dec_flag));

    p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc_flag |-> offset == (($past(offset) == MAX_V) ? '0 : $past(offset) + 1'b1));

    p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_flag |-> offset == (($past(offset) == '0) ? MAX_V : $past(offset) - 1'b1));

    p_bad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_flag |-> $stable(offset));
endmodule

// File: rtl/ptr_interp.sv
`timescale 1ns/1ps
module ptr_interp
    import ptr_pkg::*;
#(
    parameter int PTR_W   = 10,
    parameter int MAX_OFS = 782,
    parameter int MAJ     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic [BYTE_W-1:0] h1_byte,
    input  logic [BYTE_W-1:0] h2_byte,
    output logic [PTR_W-1:0]  offset,
    output logic              stuff_after_h3,
    output logic              data_in_h3,
    output logic              new_ptr,
    output logic              ptr_invalid
);
    ptr_class_e       cls;
    logic [PTR_W-1:0] rx_value;

    ptr_word_decode #(
        .PTR_W   (PTR_W),
        .MAX_OFS (MAX_OFS),
        .MAJ     (MAJ),
        .FLAG_SET(4'b1001)
    ) u_decode (
        .h1_byte (h1_byte),
        .h2_byte (h2_byte),
        .held_ofs(offset),
        .rx_value(rx_value),
        .cls     (cls)
    );

    ptr_track_fsm #(
        .PTR_W  (PTR_W),
        .MAX_OFS(MAX_OFS)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_strobe(frame_strobe),
        .cls         (cls),
        .rx_value    (rx_value),
        .offset      (offset),
        .inc_flag    (stuff_after_h3),
        .dec_flag    (data_in_h3),
        .newptr_flag (new_ptr),
        .invalid_flag(ptr_invalid)
    );

    p_load_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        new_ptr |-> offset == $past({h1_byte, h2_byte}) [PTR_W-1:0]);
endmodule

// File: tb/ptr_interp_test.sv
`timescale 1ns/1ps
module ptr_interp_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_strobe = 1'b0;
    logic [7:0] h1_byte = 8'h00;
    logic [7:0] h2_byte = 8'h00;
    logic [9:0] offset;
    logic       stuff_after_h3, data_in_h3, new_ptr, ptr_invalid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    ptr_interp uut (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .h1_byte(h1_byte), .h2_byte(h2_byte), .offset(offset),
        .stuff_after_h3(stuff_after_h3), .data_in_h3(data_in_h3),
        .new_ptr(new_ptr), .ptr_invalid(ptr_invalid)
    );

    always #4 clk = ~clk;

    // {h1, h2, expected offset, expected {inc, dec, new, invalid}}
    localparam int NV = 20;
    localparam logic [29:0] VEC [NV] = '{
        {8'h90, 8'h93, 10'd147, 4'b0010},  // R6 load 147 -> guard
        {8'h60, 8'h93, 10'd147, 4'b0000},  // R8 guard frame, normal
        {8'h62, 8'h39, 10'd148, 4'b1000},  // R3 all I bits inverted
        {8'h62, 8'h1E, 10'd148, 4'b0000},  // R9 increment in guard ignored
        {8'h60, 8'h94, 10'd148, 4'b0000},  // R8 normal
        {8'h61, 8'hC1, 10'd147, 4'b0100},  // R4 all D bits inverted
        {8'h60, 8'h93, 10'd147, 4'b0000},  // R8 guard frame
        {8'h60, 8'h95, 10'd147, 4'b0000},  // R8 differing in-range value
        {8'h63, 8'h93, 10'd147, 4'b0001},  // R7 normal word 915
        {8'h93, 8'hE8, 10'd147, 4'b0001},  // R7 load attempt 1000
        {8'h93, 8'h0E, 10'd782, 4'b0010},  // R6 load 782
        {8'h63, 8'h0E, 10'd782, 4'b0000},  // R8 guard frame
        {8'h61, 8'hA4, 10'd0,   4'b1000},  // R5 increment wraps to 0
        {8'h60, 8'h00, 10'd0,   4'b0000},  // R8 guard frame
        {8'h61, 8'h55, 10'd782, 4'b0100},  // R5 decrement wraps to 782
        {8'h90, 8'h0A, 10'd10,  4'b0010},  // R6 load accepted inside guard
        {8'h60, 8'h0A, 10'd10,  4'b0000},  // R9 guard ends, normal
        {8'h62, 8'hAA, 10'd11,  4'b1000},  // R3 exactly three I bits
        {8'h60, 8'h0B, 10'd11,  4'b0000},  // R8 guard frame
        {8'h63, 8'hF4, 10'd11,  4'b0001}   // R11 both majorities, word 1012
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] flags_now();
        return {stuff_after_h3, data_in_h3, new_ptr, ptr_invalid};
    endfunction

    task automatic send(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        h1_byte = a;
        h2_byte = b;
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 offset", 32'(offset), 0);
        chk("R2 flags", 32'(flags_now()), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle after reset", 32'(flags_now()), 0);

        // R1 field split is exercised by every table row
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][29:22], VEC[i][21:14]);
            chk($sformatf("R1 row %0d offset", i), 32'(offset), 32'(VEC[i][13:4]));
            chk($sformatf("R1 row %0d flags", i), 32'(flags_now()), 32'(VEC[i][3:0]));
            @(negedge clk);
            chk($sformatf("R10 row %0d pulse ends", i), 32'(flags_now()), 0);
        end

        // R10: a justification word without a strobe does nothing
        h1_byte = 8'h62;
        h2_byte = 8'hAA;
        repeat (4) @(negedge clk);
        chk("R10 no strobe offset", 32'(offset), 11);
        chk("R10 no strobe flags", 32'(flags_now()), 0);

        // R2: reset right after an adjustment clears the guard
        send(8'h90, 8'h05);
        chk("R6 load 5", 32'(offset), 5);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 mid-run offset", 32'(offset), 0);
        chk("R2 mid-run flags", 32'(flags_now()), 0);
        rst_n = 1'b1;
        send(8'h62, 8'hAA);
        chk("R2 no guard after reset offset", 32'(offset), 1);
        chk("R3 increment after reset", 32'(flags_now()), 32'(4'b1000));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule